// File: doc/BRIEF.md
# Parallel Display Bus Write Master

This block turns host write requests into write cycles on a parallel display-controller bus. A host presents a 16-bit word, an address and a valid flag. One configurable address bit decides whether the word is a command or pixel/parameter data. The block holds chip select asserted for the whole transfer and sequences the strobes through three programmable windows: setup, strobe and hold. Each window is a count of system clocks.

Two timing styles are supported. In the split-strobe style, a separate active-low write strobe and read strobe are used, and the panel captures data when the write strobe rises. In the enable-pulse style, a direction level (low means write) and an active-high enable pulse are used, and the transfer happens while the enable is high. The bus can be 16 bits wide, so a whole RGB565 pixel moves in one cycle. It can also be 8 bits wide, in which case each word is sent as two byte cycles on the low lane, high byte first.

The host drives the style, width and timing fields as static configuration. The block captures them, together with the word, on the cycle the word is accepted. The total write-cycle length can therefore be set to meet the panel's minimum cycle time at any clock rate.

Top module: `pbus_writer`

## Requirements
- R1: While reset is high and in the cycle after it falls, chip select, write strobe and read strobe are all high. Enable is low, direction is high and ready is high.
- R2: A word is accepted on a rising edge where valid and ready are both high. Ready is then low for exactly beats × (setup + strobe + hold) cycles, where beats is 1 for a 16-bit bus and 2 for an 8-bit bus. Ready is high again in the cycle after the final hold cycle.
- R3: The D/C output equals bit DC_BIT of the accepted address for the whole transfer: 0 marks a command and 1 marks data.
- R4: Split-strobe style (style input 0). Each beat has `setup` cycles with chip select low, data driven and write strobe high. Then come `strobe` cycles with write strobe low, then `hold` cycles with write strobe high and the data unchanged. The read strobe stays high, the enable stays low and the direction stays high.
- R5: Enable-pulse style (style input 1). The direction output is low in every cycle where chip select is low. Within each beat the enable is high for `strobe` cycles, after `setup` cycles and before `hold` cycles, with the data stable. The write strobe stays high.
- R6: With the width input 0 (16-bit bus), a word is sent in a single beat with all 16 bits on the data bus.
- R7: With the width input 1 (8-bit bus), a word is sent in two beats. The first beat carries bits 15:8 and the second carries bits 7:0, both on data bits 7:0 with bits 15:8 driven 0. Chip select stays low between the two beats.
- R8: A timing field of 0 behaves as 1 cycle.
- R9: Style, width, timing, address and data inputs are captured at acceptance. Changes to them during a transfer do not alter that transfer.
- R10: Between two words, chip select is high for at least one cycle, and back-to-back words are separated by exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_style | input | 1 | 0 = split write/read strobes, 1 = direction level plus enable pulse |
| cfg_narrow | input | 1 | 0 = 16-bit bus, 1 = 8-bit bus (two beats per word) |
| cfg_setup | input | CNT_W | Setup window in clocks (0 acts as 1) |
| cfg_strobe | input | CNT_W | Active strobe window in clocks (0 acts as 1) |
| cfg_hold | input | CNT_W | Hold window in clocks (0 acts as 1) |
| host_valid | input | 1 | Host offers a word |
| host_ready | output | 1 | Block can accept a word |
| host_addr | input | ADDR_W | Host address; bit DC_BIT selects command or data |
| host_wdata | input | 16 | Word to send |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_dc | output | 1 | Data/command select |
| bus_wr_n | output | 1 | Active-low write strobe (split-strobe style) |
| bus_rd_n | output | 1 | Active-low read strobe, always inactive |
| bus_e | output | 1 | Enable pulse (enable-pulse style) |
| bus_rw | output | 1 | Direction level, low for write (enable-pulse style) |
| bus_d | output | 16 | Data bus |

## Verification
The bench builds the block with its default parameters: a 4-bit timing field, a 4-bit address and the D/C bit at address bit 0. Because the timing fields are so narrow, it can sweep every combination of both styles, both widths and setup, strobe and hold values from 0 to 3, including the zero-as-one cases. The words run back to back, so the single idle gap is checked each time. While each word is in flight the bench scrambles every configuration and host input, and it finishes with a transfer at the maximum field value of 15 to exercise the counter limit.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_WIN  = 3;   // setup, strobe, hold

    localparam int WIN_SETUP  = 0;
    localparam int WIN_STROBE = 1;
    localparam int WIN_HOLD   = 2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic {
        STYLE_SPLIT  = 1'b0,
        STYLE_ENABLE = 1'b1
    } style_e;

    typedef struct packed {
        style_e              style;
        logic                narrow;
        logic                dc;
        logic [WORD_W-1:0]   word;
    } xfer_t;

    typedef struct packed {
        logic cs_n;
        logic dc;
        logic wr_n;
        logic rd_n;
        logic e;
        logic rw;
    } ctl_pins_t;

    // Bus value for a given beat: full word, or one byte on the low lane.
    function automatic logic [WORD_W-1:0] lane_value(input xfer_t x, input logic beat);
        logic [WORD_W-1:0] v;
        if (!x.narrow) begin
            v = x.word;
        end else if (!beat) begin
            v = {{(WORD_W-BYTE_W){1'b0}}, x.word[WORD_W-1 -: BYTE_W]};
        end else begin
            v = {{(WORD_W-BYTE_W){1'b0}}, x.word[BYTE_W-1:0]};
        end
        return v;
    endfunction

endpackage

// File: rtl/pbus_xfer_reg.sv
module pbus_xfer_reg
    import pbus_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take,
    input  logic                          style_in,
    input  logic                          narrow_in,
    input  logic                          dc_in,
    input  logic [WORD_W-1:0]             word_in,
    input  logic [N_WIN-1:0][CNT_W-1:0]   win_raw,
    output xfer_t                         xfer_q,
    output logic [N_WIN-1:0][CNT_W-1:0]   win_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [N_WIN-1:0][CNT_W-1:0] win_eff;

    // Each window length is at least one clock.
    for (genvar g = 0; g < N_WIN; g++) begin : g_clamp
        assign win_eff[g] = (win_raw[g] == '0) ? ONE : win_raw[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= '0;
            win_q  <= {N_WIN{ONE}};
        end else if (take) begin
            xfer_q.style  <= style_e'(style_in);
            xfer_q.narrow <= narrow_in;
            xfer_q.dc     <= dc_in;
            xfer_q.word   <= word_in;
            win_q         <= win_eff;
        end
    end

endmodule

// File: rtl/pbus_phase_seq.sv
module pbus_phase_seq
    import pbus_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          narrow,
    input  logic [N_WIN-1:0][CNT_W-1:0]   win,
    output phase_e                        phase,
    output logic                          beat,
    output logic                          idle
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cur_len;
    logic             win_done;
    logic             more_beats;

    always_comb begin
        unique case (phase)
            PH_SETUP:  cur_len = win[WIN_SETUP];
            PH_STROBE: cur_len = win[WIN_STROBE];
            PH_HOLD:   cur_len = win[WIN_HOLD];
            default:   cur_len = win[WIN_SETUP];
        endcase
    end

    assign win_done   = (cnt == cur_len - CNT_W'(1));
    assign more_beats = narrow && !beat;
    assign idle       = (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            beat  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        phase <= PH_SETUP;
                        beat  <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (win_done) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (win_done) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (win_done) begin
                        cnt <= '0;
                        if (more_beats) begin
                            phase <= PH_SETUP;
                            beat  <= 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pbus_pin_map.sv
module pbus_pin_map
    import pbus_pkg::*;
(
    input  phase_e             phase,
    input  logic               beat,
    input  xfer_t              xfer,
    output ctl_pins_t          pins,
    output logic [WORD_W-1:0]  data
);

    logic active;
    logic strobing;

    assign active   = (phase != PH_IDLE);
    assign strobing = (phase == PH_STROBE);

    always_comb begin
        pins.cs_n = !active;
        pins.dc   = xfer.dc;
        pins.rd_n = 1'b1;
        if (xfer.style == STYLE_SPLIT) begin
            pins.wr_n = !strobing;
            pins.e    = 1'b0;
            pins.rw   = 1'b1;
        end else begin
            pins.wr_n = 1'b1;
            pins.e    = strobing;
            pins.rw   = !active;
        end
    end

    assign data = lane_value(xfer, beat);

endmodule

// File: rtl/pbus_writer.sv
module pbus_writer
    import pbus_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int ADDR_W = 4,
    parameter int DC_BIT = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_style,
    input  logic                 cfg_narrow,
    input  logic [CNT_W-1:0]     cfg_setup,
    input  logic [CNT_W-1:0]     cfg_strobe,
    input  logic [CNT_W-1:0]     cfg_hold,
    input  logic                 host_valid,
    output logic                 host_ready,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [WORD_W-1:0]    host_wdata,
    output logic                 bus_cs_n,
    output logic                 bus_dc,
    output logic                 bus_wr_n,
    output logic                 bus_rd_n,
    output logic                 bus_e,
    output logic                 bus_rw,
    output logic [WORD_W-1:0]    bus_d
);

    logic                         accept;
    logic                         seq_idle;
    logic [N_WIN-1:0][CNT_W-1:0]  win_raw;
    logic [N_WIN-1:0][CNT_W-1:0]  win_q;
    xfer_t                        xfer_q;
    phase_e                       phase;
    logic                         beat;
    ctl_pins_t                    pins;
    logic [ADDR_W-1:0]            addr_unused_bits;

    // Only the D/C selector bit of the address matters.
    assign addr_unused_bits = host_addr;

    assign win_raw[WIN_SETUP]  = cfg_setup;
    assign win_raw[WIN_STROBE] = cfg_strobe;
    assign win_raw[WIN_HOLD]   = cfg_hold;

    assign host_ready = seq_idle;
    assign accept     = host_valid && seq_idle;

    pbus_xfer_reg #(.CNT_W(CNT_W)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .take      (accept),
        .style_in  (cfg_style),
        .narrow_in (cfg_narrow),
        .dc_in     (host_addr[DC_BIT]),
        .word_in   (host_wdata),
        .win_raw   (win_raw),
        .xfer_q    (xfer_q),
        .win_q     (win_q)
    );

    pbus_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .narrow (xfer_q.narrow),
        .win    (win_q),
        .phase  (phase),
        .beat   (beat),
        .idle   (seq_idle)
    );

    pbus_pin_map u_pins (
        .phase (phase),
        .beat  (beat),
        .xfer  (xfer_q),
        .pins  (pins),
        .data  (bus_d)
    );

    assign bus_cs_n = pins.cs_n;
    assign bus_dc   = pins.dc;
    assign bus_wr_n = pins.wr_n;
    assign bus_rd_n = pins.rd_n;
    assign bus_e    = pins.e;
    assign bus_rw   = pins.rw;

endmodule

// File: rtl/pbus_writer_chk.sv
module pbus_writer_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              host_valid,
    input logic              host_ready,
    input logic              bus_cs_n,
    input logic              bus_wr_n,
    input logic              bus_e,
    input logic              bus_rw,
    input logic [WORD_W-1:0] bus_d
);

    // R4
    wr_fall_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_wr_n) |-> ($stable(bus_d) && !bus_cs_n));

    // R4
    wr_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr_n) |-> ($stable(bus_d) && !bus_cs_n));

    // R5
    e_rise_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_e) |-> ($stable(bus_d) && !bus_cs_n && !bus_rw));

    // R5
    e_fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_e) |-> ($stable(bus_d) && !bus_cs_n && !bus_rw));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!bus_wr_n && bus_e));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> !host_ready);

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> (!host_ready && !bus_cs_n));

    // R10
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_cs_n) |-> (host_ready && bus_wr_n && !bus_e));

endmodule

bind pbus_writer pbus_writer_chk #(.WORD_W(16)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .bus_cs_n   (bus_cs_n),
    .bus_wr_n   (bus_wr_n),
    .bus_e      (bus_e),
    .bus_rw     (bus_rw),
    .bus_d      (bus_d)
);

// File: tb/tb_pbus_writer.sv
`timescale 1ns/1ps
module tb_pbus_writer;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_style, cfg_narrow;
    logic [3:0]  cfg_setup, cfg_strobe, cfg_hold;
    logic        host_valid;
    logic        host_ready;
    logic [3:0]  host_addr;
    logic [15:0] host_wdata;
    logic        bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_e, bus_rw;
    logic [15:0] bus_d;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    pbus_writer dut (
        .clk(clk), .rst(rst),
        .cfg_style(cfg_style), .cfg_narrow(cfg_narrow),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .host_valid(host_valid), .host_ready(host_ready),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .bus_cs_n(bus_cs_n), .bus_dc(bus_dc), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_e(bus_e), .bus_rw(bus_rw), .bus_d(bus_d)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    // Called at a negedge in an idle cycle; returns at the negedge after the word.
    task automatic send(input logic mode, input logic nar, input logic [3:0] s,
                        input logic [3:0] w, input logic [3:0] h,
                        input logic [15:0] word, input logic dcb);
        int es = eff(s);
        int ew = eff(w);
        int eh = eff(h);
        int beats = nar ? 2 : 1;
        string zt = (s == 0 || w == 0 || h == 0) ? "R8 " : "";
        cfg_style  = mode;
        cfg_narrow = nar;
        cfg_setup  = s;
        cfg_strobe = w;
        cfg_hold   = h;
        host_wdata = word;
        host_addr  = {word[3:1], dcb};
        host_valid = 1'b1;
        chk("R10 ready in idle gap", host_ready, 1);
        chk("R10 cs_n high in idle gap", bus_cs_n, 1);
        @(negedge clk);
        host_valid = 1'b0;
        // R9: scramble every captured input during the transfer
        cfg_style  = ~mode;
        cfg_narrow = ~nar;
        cfg_setup  = s + 4'd5;
        cfg_strobe = w + 4'd7;
        cfg_hold   = h + 4'd3;
        host_wdata = ~word;
        host_addr  = ~host_addr;
        for (int b = 0; b < beats; b++) begin
            for (int p = 0; p < 3; p++) begin
                int len = (p == 0) ? es : ((p == 1) ? ew : eh);
                for (int k = 0; k < len; k++) begin
                    logic [15:0] ed;
                    ed = !nar ? word : (b == 0 ? {8'h00, word[15:8]} : {8'h00, word[7:0]});
                    chk("R2 ready low in transfer", host_ready, 0);
                    chk({zt, "R4 R7 cs_n low in transfer"}, bus_cs_n, 0);
                    chk("R3 R9 dc from address bit", bus_dc, dcb);
                    chk(nar ? "R7 R9 byte lane data" : "R6 R9 word data", bus_d, ed);
                    chk("R4 rd_n inactive", bus_rd_n, 1);
                    if (!mode) begin
                        chk({zt, "R4 wr_n window"}, bus_wr_n, (p == 1) ? 0 : 1);
                        chk("R4 e idle in split style", bus_e, 0);
                        chk("R4 rw idle in split style", bus_rw, 1);
                    end else begin
                        chk({zt, "R5 e window"}, bus_e, (p == 1) ? 1 : 0);
                        chk("R5 rw low for write", bus_rw, 0);
                        chk("R5 wr_n idle in enable style", bus_wr_n, 1);
                    end
                    @(negedge clk);
                end
            end
        end
        chk("R2 ready back after hold", host_ready, 1);
        chk("R10 cs_n released after word", bus_cs_n, 1);
        chk("R5 rw released after word", bus_rw, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        rst = 1'b1;
        cfg_style = 0; cfg_narrow = 0;
        cfg_setup = 0; cfg_strobe = 0; cfg_hold = 0;
        host_valid = 0; host_addr = 0; host_wdata = 0;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", bus_cs_n, 1);
        chk("R1 ready in reset", host_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n after reset", bus_cs_n, 1);
        chk("R1 wr_n after reset", bus_wr_n, 1);
        chk("R1 rd_n after reset", bus_rd_n, 1);
        chk("R1 e after reset", bus_e, 0);
        chk("R1 rw after reset", bus_rw, 1);
        chk("R1 ready after reset", host_ready, 1);

        for (int m = 0; m < 2; m++)
            for (int n = 0; n < 2; n++)
                for (int s = 0; s < 4; s++)
                    for (int w = 0; w < 4; w++)
                        for (int h = 0; h < 4; h++) begin
                            logic [15:0] word;
                            word = 16'hA5C3 ^ 16'(idx * 16'h1F1D);
                            send(m[0], n[0], 4'(s), 4'(w), 4'(h), word,
                                 1'(idx) ^ 1'(idx >> 3));
                            idx++;
                        end

        // Counter limit with the widest windows, both styles, 8-bit bus
        send(1'b0, 1'b1, 4'd15, 4'd15, 4'd15, 16'hBEEF, 1'b1);
        send(1'b1, 1'b1, 4'd15, 4'd15, 4'd15, 16'h1234, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule